// File: doc/BRIEF.md
# Reference Rate Classifier

This block watches one incoming clock reference and reports whether it is toggling and which standard telecom rate it carries. The reference is brought into the local system clock domain through a synchroniser, and its rising edges are counted over a gate window whose length in system cycles is set by an input. At the end of each window the edge count is compared with the expected count of every supported rate. The first rate whose capture band holds the count sets a 4-bit rate code.

A second, programmable and usually tighter tolerance decides the in-range flag. An idle timer clears the activity flag when no edge has arrived for a programmable number of cycles. All results are registered together at the window end and then held until the next window ends. A one-cycle strobe marks each update. One instance is placed per reference input. The reference must stay below half the system clock rate, so the top code is only reachable with a system clock above about 156 MHz.

Top module: `ref_freq_classifier`

## Requirements
- R1: At each window end, with the reference active, `freq_code` gives the matched rate: 1 = 8 kHz, 2 = 1.544 MHz, 3 = 2.048 MHz, 4 = 12.96 MHz, 5 = 19.44 MHz, 6 = 25.92 MHz, 7 = 38.88 MHz, 8 = 51.84 MHz, 9 = 77.76 MHz. Code k matches when |count - E_k| <= (E_k >> CAP_SHIFT) + 1, where E_k = floor(gate_len * rate_kHz / SYS_KHZ). The lowest matching code wins.
- R2: `freq_code` never takes the values 10 to 15.
- R3: `active` is 1 at a window end if a rising edge arrived within the last `idle_lim` cycles, and 0 otherwise. When it is 0, `freq_code` is 0 and `in_range` is 0.
- R4: `in_range` is 1 only when a code k was matched and |count - E_k| <= (E_k >> `tol_shift`) + 1.
- R5: `avail` equals `active` AND `in_range`.
- R6: An active reference whose count matches no capture band reports code 0 with `active` = 1 and `in_range` = 0.
- R7: `upd` pulses once every `gate_len` cycles while `gate_len` is held constant. `freq_code`, `active` and `in_range` change only in a cycle where `upd` is 1.
- R8: After reset, all outputs are 0 until the first window end.
- R9: A count inside the capture band but outside the tight tolerance still reports the matched code, with `in_range` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_in | input | 1 | Reference clock being monitored |
| gate_len | input | GATE_W | Window length in system cycles |
| idle_lim | input | IDLE_W | Cycles without an edge before the input counts as idle |
| tol_shift | input | 4 | Right shift applied to the expected count to form the in-range tolerance |
| freq_code | output | 4 | Detected rate code, 0 when there is no signal or no match |
| active | output | 1 | Edges are present |
| in_range | output | 1 | Count lies within the programmable tolerance |
| avail | output | 1 | Active and in range |
| upd | output | 1 | One-cycle strobe at each result update |

## Verification
The hardest outcome to reach from the ports is the split between the wide capture band and the narrow in-range band, where a code is reported while the range flag stays low. The bench reaches it with a reference about 7 % above 12.96 MHz. It then widens `tol_shift` on the same reference and shows the range flag return. A second hard case is the loss of the slowest rate without a false idle in between. This needs an idle limit longer than one 8 kHz period. The stimulus then stops the reference and waits more than that limit before it expects the flags to clear.

// File: rtl/rfc_pkg.sv
package rfc_pkg;
  localparam int NCODE = 10;
  typedef logic [3:0] fcode_t;
  localparam fcode_t CODE_NONE = 4'd0;

  // nominal rate in kHz for each code; code 0 means no signal
  function automatic int unsigned rate_khz(input int idx);
    case (idx)
      1: rate_khz = 8;
      2: rate_khz = 1544;
      3: rate_khz = 2048;
      4: rate_khz = 12960;
      5: rate_khz = 19440;
      6: rate_khz = 25920;
      7: rate_khz = 38880;
      8: rate_khz = 51840;
      9: rate_khz = 77760;
      default: rate_khz = 0;
    endcase
  endfunction
endpackage

// File: rtl/rfc_edge_sync.sv
module rfc_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_in,
  output logic edge_pulse
);
  localparam int TAPS = SYNC_STAGES + 1;

  logic [TAPS-1:0] sync_q, sync_d;

  always_comb begin
    sync_d = {sync_q[TAPS-2:0], ref_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign edge_pulse = sync_q[TAPS-2] & ~sync_q[TAPS-1];

  // a rising edge needs a low sample in between, so pulses never touch (R3)
  assert_edge_spaced_R3: assert property (@(posedge clk) disable iff (!rst_n)
    edge_pulse |=> !edge_pulse);
endmodule

// File: rtl/rfc_gate.sv
module rfc_gate #(
  parameter int GATE_W = 24,
  parameter int IDLE_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              edge_pulse,
  input  logic [GATE_W-1:0] gate_len,
  input  logic [IDLE_W-1:0] idle_lim,
  output logic              win_end,
  output logic [GATE_W-1:0] win_count,
  output logic              active_now
);
  localparam logic [IDLE_W-1:0] IDLE_MAX = '1;

  logic [GATE_W-1:0] wcnt_q, wcnt_d;
  logic [GATE_W-1:0] ecnt_q, ecnt_d;
  logic [IDLE_W-1:0] idle_q, idle_d;
  logic [GATE_W-1:0] last_idx;

  always_comb begin
    last_idx  = (gate_len == '0) ? '0 : gate_len - 1'b1;
    win_end   = (wcnt_q >= last_idx);
    win_count = ecnt_q + GATE_W'(edge_pulse);
    wcnt_d    = win_end ? '0 : wcnt_q + 1'b1;
    ecnt_d    = win_end ? '0 : win_count;
    if (edge_pulse)            idle_d = '0;
    else if (idle_q == IDLE_MAX) idle_d = idle_q;
    else                       idle_d = idle_q + 1'b1;
    active_now = edge_pulse | (idle_q < idle_lim);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wcnt_q <= '0;
      ecnt_q <= '0;
      idle_q <= IDLE_MAX;
    end else begin
      wcnt_q <= wcnt_d;
      ecnt_q <= ecnt_d;
      idle_q <= idle_d;
    end
  end

  // no more edges than elapsed cycles in the window (R1)
  assert_count_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    win_count <= wcnt_q + 1'b1);
  // an edge always counts as recent activity (R3)
  assert_edge_active_R3: assert property (@(posedge clk) disable iff (!rst_n)
    edge_pulse |-> active_now);
endmodule

// File: rtl/rfc_classify.sv
module rfc_classify
  import rfc_pkg::*;
#(
  parameter int GATE_W    = 24,
  parameter int SYS_KHZ   = 125000,
  parameter int CAP_SHIFT = 3
) (
  input  logic [GATE_W-1:0] count,
  input  logic [GATE_W-1:0] gate_len,
  input  logic [3:0]        tol_shift,
  output fcode_t            code,
  output logic              tight_ok
);
  localparam longint unsigned SYS = longint'(SYS_KHZ);

  logic [NCODE-1:1] cap_hit;
  logic [NCODE-1:1] tight_hit;

  for (genvar k = 1; k < NCODE; k++) begin : g_rate
    localparam longint unsigned RATE = longint'(rate_khz(k));
    logic [63:0] expect_cnt, diff, cap_band, tight_band, cnt64;
    always_comb begin
      cnt64      = 64'(count);
      expect_cnt = (64'(gate_len) * RATE) / SYS;
      diff       = (cnt64 > expect_cnt) ? cnt64 - expect_cnt : expect_cnt - cnt64;
      cap_band   = (expect_cnt >> CAP_SHIFT) + 64'd1;
      tight_band = (expect_cnt >> tol_shift) + 64'd1;
      cap_hit[k]   = (diff <= cap_band);
      tight_hit[k] = (diff <= tight_band);
    end
  end

  always_comb begin
    code     = CODE_NONE;
    tight_ok = 1'b0;
    for (int k = NCODE - 1; k >= 1; k--) begin
      if (cap_hit[k]) begin
        code     = fcode_t'(k);
        tight_ok = tight_hit[k];
      end
    end
  end
endmodule

// File: rtl/ref_freq_classifier.sv
module ref_freq_classifier
  import rfc_pkg::*;
#(
  parameter int GATE_W      = 24,
  parameter int IDLE_W      = 24,
  parameter int SYS_KHZ     = 125000,
  parameter int CAP_SHIFT   = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_in,
  input  logic [GATE_W-1:0] gate_len,
  input  logic [IDLE_W-1:0] idle_lim,
  input  logic [3:0]        tol_shift,
  output logic [3:0]        freq_code,
  output logic              active,
  output logic              in_range,
  output logic              avail,
  output logic              upd
);
  logic [1:0] rst_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_n_s = rst_q[1];

  logic              edge_pulse;
  logic              win_end;
  logic [GATE_W-1:0] win_count;
  logic              active_now;
  fcode_t            cls_code;
  logic              cls_tight;

  rfc_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n_s), .ref_in(ref_in), .edge_pulse(edge_pulse)
  );

  rfc_gate #(.GATE_W(GATE_W), .IDLE_W(IDLE_W)) u_gate (
    .clk(clk), .rst_n(rst_n_s), .edge_pulse(edge_pulse),
    .gate_len(gate_len), .idle_lim(idle_lim),
    .win_end(win_end), .win_count(win_count), .active_now(active_now)
  );

  rfc_classify #(.GATE_W(GATE_W), .SYS_KHZ(SYS_KHZ), .CAP_SHIFT(CAP_SHIFT)) u_cls (
    .count(win_count), .gate_len(gate_len), .tol_shift(tol_shift),
    .code(cls_code), .tight_ok(cls_tight)
  );

  fcode_t code_q, code_d;
  logic   act_q, act_d, rng_q, rng_d, upd_q, upd_d;

  always_comb begin
    code_d = code_q;
    act_d  = act_q;
    rng_d  = rng_q;
    upd_d  = win_end;
    if (win_end) begin
      act_d  = active_now;
      code_d = active_now ? cls_code : CODE_NONE;
      rng_d  = active_now && (cls_code != CODE_NONE) && cls_tight;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      code_q <= CODE_NONE;
      act_q  <= 1'b0;
      rng_q  <= 1'b0;
      upd_q  <= 1'b0;
    end else begin
      code_q <= code_d;
      act_q  <= act_d;
      rng_q  <= rng_d;
      upd_q  <= upd_d;
    end
  end

  assign freq_code = code_q;
  assign active    = act_q;
  assign in_range  = rng_q;
  assign avail     = act_q & rng_q;
  assign upd       = upd_q;

  assert_code_legal_R2: assert property (@(posedge clk) disable iff (!rst_n_s)
    freq_code <= 4'd9);
  assert_idle_clears_R3: assert property (@(posedge clk) disable iff (!rst_n_s)
    !active |-> (freq_code == CODE_NONE && !in_range));
  assert_range_needs_code_R4: assert property (@(posedge clk) disable iff (!rst_n_s)
    in_range |-> (freq_code != CODE_NONE));
  assert_hold_between_R7: assert property (@(posedge clk) disable iff (!rst_n_s)
    !upd |-> ($stable(freq_code) && $stable(active) && $stable(in_range)));
endmodule

// File: tb/ref_freq_classifier_tb.sv
`timescale 1ns/1ps
module ref_freq_classifier_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ref_in;
  logic [23:0] gate_len;
  logic [23:0] idle_lim;
  logic [3:0]  tol_shift;
  logic [3:0]  freq_code;
  logic        active, in_range, avail, upd;

  always #4 clk = ~clk;

  ref_freq_classifier u_dut (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .gate_len(gate_len),
    .idle_lim(idle_lim), .tol_shift(tol_shift), .freq_code(freq_code),
    .active(active), .in_range(in_range), .avail(avail), .upd(upd)
  );

  typedef struct {
    logic [3:0] code;
    logic       act;
    logic       rng;
    string      req;
  } exp_t;

  exp_t sb_q[$];
  int   checks = 0;
  int   errors = 0;
  int   cyc = 0;
  int   last_upd = 0;
  int   last_gap = 0;
  int   stab_err = 0;
  logic [3:0] snap_code = 4'd0;
  logic       snap_act = 1'b0, snap_rng = 1'b0;
  real  half_ns = 0.0;

  // reference generator; half_ns of zero holds the input low
  initial begin
    ref_in = 1'b0;
    forever begin
      if (half_ns > 0.0) begin
        #(half_ns) ref_in = ~ref_in;
      end else begin
        ref_in = 1'b0;
        #8;
      end
    end
  end

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: pops one expectation per result strobe
  always @(negedge clk) begin
    if (rst_n) begin
      if (upd) begin
        last_gap = cyc - last_upd;
        last_upd = cyc;
        snap_code = freq_code; snap_act = active; snap_rng = in_range;
        if (sb_q.size() > 0) begin
          exp_t e;
          e = sb_q.pop_front();
          checks++;
          if (freq_code !== e.code || active !== e.act || in_range !== e.rng ||
              avail !== (e.act & e.rng)) begin
            errors++;
            $display("FAIL %s: code=%0d act=%0b rng=%0b avail=%0b expected code=%0d act=%0b rng=%0b avail=%0b",
                     e.req, freq_code, active, in_range, avail, e.code, e.act, e.rng, e.act & e.rng);
          end
          checks++;
          if (freq_code > 4'd9) begin
            errors++;
            $display("FAIL R2: code=%0d expected a value of 0 to 9", freq_code);
          end
        end
      end else if (freq_code !== snap_code || active !== snap_act || in_range !== snap_rng) begin
        stab_err++;
      end
    end
  end

  task automatic run_rate(input real khz, input logic [3:0] c, input logic a,
                          input logic r, input int settle, input string req);
    half_ns = (khz > 0.0) ? 1.0e6 / (2.0 * khz) : 0.0;
    repeat (settle) @(negedge clk iff upd);
    @(posedge clk);
    sb_q.push_back('{code: c, act: a, rng: r, req: req});
    wait (sb_q.size() == 0);
    @(posedge clk);
  endtask

  initial begin
    rst_n = 1'b0;
    gate_len = 24'd2000;
    idle_lim = 24'd500;
    tol_shift = 4'd5;
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (20) @(negedge clk);
    checks++;   // R8 reset state
    if (freq_code !== 4'd0 || active !== 1'b0 || in_range !== 1'b0 || avail !== 1'b0 || upd !== 1'b0) begin
      errors++;
      $display("FAIL R8: code=%0d act=%0b rng=%0b avail=%0b upd=%0b expected all 0",
               freq_code, active, in_range, avail, upd);
    end
    run_rate(1544.0,  4'd2, 1'b1, 1'b1, 1, "R1 1.544M R5");
    run_rate(2048.0,  4'd3, 1'b1, 1'b1, 1, "R1 2.048M");
    run_rate(12960.0, 4'd4, 1'b1, 1'b1, 1, "R1 12.96M");
    run_rate(19440.0, 4'd5, 1'b1, 1'b1, 1, "R1 19.44M");
    run_rate(25920.0, 4'd6, 1'b1, 1'b1, 1, "R1 25.92M");
    run_rate(38880.0, 4'd7, 1'b1, 1'b1, 1, "R1 38.88M");
    run_rate(51840.0, 4'd8, 1'b1, 1'b1, 1, "R1 51.84M");
    run_rate(5000.0,  4'd0, 1'b1, 1'b0, 1, "R6 unmatched 5M");
    run_rate(13867.0, 4'd4, 1'b1, 1'b0, 1, "R9 capture only, R5 avail low");
    tol_shift = 4'd3;
    run_rate(13867.0, 4'd4, 1'b1, 1'b1, 1, "R4 widened tolerance");
    tol_shift = 4'd5;
    run_rate(0.0,     4'd0, 1'b0, 1'b0, 1, "R3 idle short limit");
    gate_len = 24'd1000;
    run_rate(19440.0, 4'd5, 1'b1, 1'b1, 2, "R7 gate 1000");
    checks++;   // R7 strobe spacing
    if (last_gap != 1000) begin
      errors++;
      $display("FAIL R7: upd spacing=%0d expected=1000", last_gap);
    end
    gate_len = 24'd2000;
    idle_lim = 24'd20000;
    run_rate(8.0,     4'd1, 1'b1, 1'b1, 6, "R1 8k");
    run_rate(0.0,     4'd0, 1'b0, 1'b0, 11, "R3 idle after 8k");
    checks++;   // R7 outputs held between strobes
    if (stab_err != 0) begin
      errors++;
      $display("FAIL R7: %0d output changes without upd, expected 0", stab_err);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1520000;
    checks++;
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule